// File: doc/BRIEF.md
# PMP configuration register bank

This block holds the physical memory protection settings of a 32-bit RISC-V core. Software reaches it through a CSR access port: a write strobe, a 12-bit CSR number and a 32-bit data word go in, and read data for whatever PMP CSR is addressed comes back combinationally in the same cycle. The config CSRs (0x3A0 to 0x3A3) each pack four one-byte entry settings. The address CSRs (0x3B0 to 0x3BF) each hold one address word.

The architecture names sixteen entries, but only the first `NUM_IMPL` (default 4) have storage. Every implemented entry's config byte and address word is also driven out on flat buses, so a separate matcher can use them. Writes are filtered as they land. Reserved config bits are dropped. An address word keeps only its low 30 bits. An entry whose lock bit is set refuses all further writes until reset.

The bank has no opinion about accesses that are not PMP CSRs. It ignores their writes and answers reads of them with zero data and a low hit flag.

Top module: `pmp_cfg_bank`

## Requirements
- R1: After a synchronous active-low reset, every config byte and address word is zero. Every PMP CSR therefore reads 0 and both export buses are 0.
- R2: A write to address CSR 0x3B0+i of an implemented, unlocked entry stores write-data bits 29..0. A later read of that CSR returns those bits with bits 31..30 equal to zero.
- R3: Entry i's config byte sits in config CSR 0x3A0+i/4, at bits 8*(i%4)+7 down to 8*(i%4). Export bus `entry_cfg` carries entry i at bits 8*i+7..8*i, and `entry_addr` carries entry i's zero-extended word at bits 32*i+31..32*i.
- R4: A config write keeps only bits 7, 4, 3, 2, 1 and 0 of each byte (mask 0x9F). Bits 6 and 5 of every config byte always read as zero.
- R5: A config CSR write updates each implemented, unlocked entry's byte on its own. The bytes of locked entries in the same CSR keep their previous value.
- R6: While bit 7 (lock) of an entry's config byte is 1, writes to that entry's config byte and to its address CSR change nothing. Only reset clears the lock.
- R7: Entries numbered NUM_IMPL to 15 have no storage. Their address CSRs read 0, their config bytes read 0, and writes to them change nothing.
- R8: For a CSR number outside 0x3A0..0x3A3 and 0x3B0..0x3BF, `csr_hit` is 0 and `csr_rdata` is 0. A write there changes no stored value.
- R9: A write takes effect at the rising clock edge at which `csr_wr_en` is sampled high. Read data in the cycle of the write still shows the old value, and read data after that edge shows the new value.
- R10: `csr_hit` is 1 for all twenty PMP CSR numbers, including those of unimplemented entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| csr_wr_en | input | 1 | Write strobe for the addressed CSR |
| csr_addr | input | 12 | CSR number of the access |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Combinational read data for csr_addr |
| csr_hit | output | 1 | csr_addr names a PMP CSR |
| entry_cfg | output | NUM_IMPL*8 | Config byte of each implemented entry |
| entry_addr | output | NUM_IMPL*32 | Zero-extended address word of each entry |

## Verification
Stored state shows up at the ports in two ways. It is readable on `csr_rdata` in the same cycle it is addressed, and it is always visible on the export buses. A wrong byte merge, a missing mask or a lock leak therefore appears right after the edge that applied the faulty write. The bench compares the full readback and both export buses against its own model after every write. A lock that silently clears, or a write that lands on the wrong entry, is caught at the first later read of the damaged entry. The bench makes such reads right after directed lock sequences and across a long random mix of config, address and foreign CSR writes.

// File: rtl/pmp_bank_pkg.sv
// Package: constants and the decoded-access type shared by the PMP bank.
// Assumes a 32-bit CSR data path and the standard PMP CSR numbering.
package pmp_bank_pkg;
    localparam int XLEN            = 32;
    localparam int CSR_AW          = 12;
    localparam int CFG_W           = 8;
    localparam int ENTRIES_PER_CFG = XLEN / CFG_W;
    localparam int ARCH_ENTRIES    = 16;
    localparam int CFG_CSRS        = ARCH_ENTRIES / ENTRIES_PER_CFG;
    localparam int ADDR_KEEP       = 30;
    localparam int CFG_SEL_W       = $clog2(CFG_CSRS);
    localparam int ENT_SEL_W       = $clog2(ARCH_ENTRIES);
    localparam int LOCK_BIT        = 7;

    localparam logic [CSR_AW-1:0] CFG_BASE  = 12'h3A0;
    localparam logic [CSR_AW-1:0] ADDR_BASE = 12'h3B0;
    localparam logic [CFG_W-1:0]  CFG_LEGAL = 8'h9F;

    typedef struct packed {
        logic                 is_cfg;
        logic                 is_addr;
        logic [CFG_SEL_W-1:0] cfg_sel;
        logic [ENT_SEL_W-1:0] addr_sel;
    } csr_dec_t;
endpackage

// File: rtl/pmp_csr_decode.sv
// Module: pmp_csr_decode
// Classifies a CSR number as a PMP config CSR, a PMP address CSR or neither,
// and gives the index within its range. Purely combinational.
module pmp_csr_decode
    import pmp_bank_pkg::*;
(
    input  logic [CSR_AW-1:0] addr_i,
    output csr_dec_t          dec_o
);
    logic [CSR_AW-1:0] cfg_off;
    logic [CSR_AW-1:0] adr_off;

    // Offsets of the access from the base of each range.
    always_comb begin
        cfg_off = addr_i - CFG_BASE;
        adr_off = addr_i - ADDR_BASE;
    end

    // Range checks and index extraction.
    always_comb begin
        dec_o          = '0;
        dec_o.is_cfg   = (addr_i >= CFG_BASE) && (cfg_off < CSR_AW'(CFG_CSRS));
        dec_o.is_addr  = (addr_i >= ADDR_BASE) && (adr_off < CSR_AW'(ARCH_ENTRIES));
        dec_o.cfg_sel  = cfg_off[CFG_SEL_W-1:0];
        dec_o.addr_sel = adr_off[ENT_SEL_W-1:0];
    end
endmodule

// File: rtl/pmp_entry_reg.sv
// Module: pmp_entry_reg
// Storage for one implemented PMP entry: a masked config byte and a 30-bit
// address word. Assumes the parent selects this entry's byte of the write
// data. Once the lock bit is set, only reset changes the entry.
module pmp_entry_reg
    import pmp_bank_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  csr_dec_t             dec_i,
    input  logic [CFG_W-1:0]     cfg_byte_i,
    input  logic [ADDR_KEEP-1:0] addr_word_i,
    output logic [CFG_W-1:0]     cfg_o,
    output logic [ADDR_KEEP-1:0] addr_o
);
    localparam logic [CFG_SEL_W-1:0] MY_CSR = CFG_SEL_W'(IDX / ENTRIES_PER_CFG);
    localparam logic [ENT_SEL_W-1:0] MY_ENT = ENT_SEL_W'(IDX);

    logic [CFG_W-1:0]     cfg_q;
    logic [ADDR_KEEP-1:0] addr_q;
    logic                 lock_q;
    logic                 hit_cfg;
    logic                 hit_adr;

    // Which of this entry's registers the current access targets.
    always_comb begin
        lock_q  = cfg_q[LOCK_BIT];
        hit_cfg = wr_en_i && dec_i.is_cfg  && (dec_i.cfg_sel  == MY_CSR);
        hit_adr = wr_en_i && dec_i.is_addr && (dec_i.addr_sel == MY_ENT);
    end

    // Register update: reset clears, a lock freezes, otherwise masked writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            addr_q <= '0;
        end else if (!lock_q) begin
            if (hit_cfg) cfg_q  <= cfg_byte_i & CFG_LEGAL;
            if (hit_adr) addr_q <= addr_word_i;
        end
    end

    assign cfg_o  = cfg_q;
    assign addr_o = addr_q;

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && rst_n) |=> ($stable(cfg_q) && $stable(addr_q)));

    // R2
    addr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_adr && !lock_q) |=> (addr_o == $past(addr_word_i)));

    // R4
    cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_cfg && !lock_q) |=> (cfg_o == ($past(cfg_byte_i) & 8'h9F)));
endmodule

// File: rtl/pmp_read_mux.sv
// Module: pmp_read_mux
// Builds combinational read data for the addressed PMP CSR from the stored
// entries. Bytes and words of unimplemented entries read as zero.
module pmp_read_mux
    import pmp_bank_pkg::*;
#(
    parameter int NUM_IMPL = 4
) (
    input  csr_dec_t                      dec_i,
    input  logic [NUM_IMPL*CFG_W-1:0]     cfg_all_i,
    input  logic [NUM_IMPL*ADDR_KEEP-1:0] addr_all_i,
    output logic [XLEN-1:0]               rdata_o,
    output logic                          hit_o
);
    // Select the config lanes or the address word the access names.
    always_comb begin
        rdata_o = '0;
        if (dec_i.is_cfg) begin
            for (int e = 0; e < NUM_IMPL; e++) begin
                if (dec_i.cfg_sel == CFG_SEL_W'(e / ENTRIES_PER_CFG))
                    rdata_o[(e % ENTRIES_PER_CFG)*CFG_W +: CFG_W] = cfg_all_i[e*CFG_W +: CFG_W];
            end
        end else if (dec_i.is_addr) begin
            for (int e = 0; e < NUM_IMPL; e++) begin
                if (dec_i.addr_sel == ENT_SEL_W'(e))
                    rdata_o = {{(XLEN-ADDR_KEEP){1'b0}}, addr_all_i[e*ADDR_KEEP +: ADDR_KEEP]};
            end
        end
    end

    // Any PMP CSR counts as a hit, implemented or not.
    assign hit_o = dec_i.is_cfg | dec_i.is_addr;
endmodule

// File: rtl/pmp_cfg_bank.sv
// Module: pmp_cfg_bank (top)
// PMP config and address CSR bank with NUM_IMPL implemented entries out of
// the sixteen the architecture names. Assumes one CSR access per cycle and
// a write strobe that is valid only with a stable address and data.
module pmp_cfg_bank
    import pmp_bank_pkg::*;
#(
    parameter int NUM_IMPL = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  csr_wr_en,
    input  logic [11:0]           csr_addr,
    input  logic [31:0]           csr_wdata,
    output logic [31:0]           csr_rdata,
    output logic                  csr_hit,
    output logic [NUM_IMPL*8-1:0] entry_cfg,
    output logic [NUM_IMPL*32-1:0] entry_addr
);
    csr_dec_t                      dec;
    logic [NUM_IMPL*CFG_W-1:0]     cfg_all;
    logic [NUM_IMPL*ADDR_KEEP-1:0] addr_all;

    pmp_csr_decode u_dec (
        .addr_i (csr_addr),
        .dec_o  (dec)
    );

    for (genvar e = 0; e < NUM_IMPL; e++) begin : g_entry
        localparam int LANE = e % ENTRIES_PER_CFG;
        pmp_entry_reg #(.IDX(e)) u_ent (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en_i     (csr_wr_en),
            .dec_i       (dec),
            .cfg_byte_i  (csr_wdata[LANE*CFG_W +: CFG_W]),
            .addr_word_i (csr_wdata[ADDR_KEEP-1:0]),
            .cfg_o       (cfg_all[e*CFG_W +: CFG_W]),
            .addr_o      (addr_all[e*ADDR_KEEP +: ADDR_KEEP])
        );
        // Export the entry, address zero-extended to the CSR width.
        assign entry_cfg[e*8 +: 8]   = cfg_all[e*CFG_W +: CFG_W];
        assign entry_addr[e*32 +: 32] = {{(XLEN-ADDR_KEEP){1'b0}}, addr_all[e*ADDR_KEEP +: ADDR_KEEP]};
    end

    pmp_read_mux #(.NUM_IMPL(NUM_IMPL)) u_rd (
        .dec_i      (dec),
        .cfg_all_i  (cfg_all),
        .addr_all_i (addr_all),
        .rdata_o    (csr_rdata),
        .hit_o      (csr_hit)
    );

    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_hit |-> (csr_rdata == 32'h0));

    // R4
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_hit && (csr_addr < 12'h3B0)) |-> ((csr_rdata & 32'h6060_6060) == 32'h0));

    // R2
    addr_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_hit && (csr_addr >= 12'h3B0)) |-> (csr_rdata[31:30] == 2'b00));
endmodule

// File: tb/pmp_cfg_bank_test.sv
// Bench for pmp_cfg_bank: directed corners plus seeded random accesses,
// all compared against a model written from the requirements.
module pmp_cfg_bank_test;
    localparam int NI = 4;
    localparam time HALF = 2.5ns;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           csr_wr_en = 1'b0;
    logic [11:0]    csr_addr = '0;
    logic [31:0]    csr_wdata = '0;
    logic [31:0]    csr_rdata;
    logic           csr_hit;
    logic [NI*8-1:0]  entry_cfg;
    logic [NI*32-1:0] entry_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0]  m_cfg  [NI];
    logic [29:0] m_addr [NI];

    pmp_cfg_bank #(.NUM_IMPL(NI)) uut (
        .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_hit(csr_hit),
        .entry_cfg(entry_cfg), .entry_addr(entry_addr)
    );

    always #HALF clk = ~clk;

    function automatic logic exp_hit(input logic [11:0] a);
        return (a >= 12'h3A0 && a <= 12'h3A3) || (a >= 12'h3B0 && a <= 12'h3BF);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        logic [31:0] r = '0;
        if (a >= 12'h3A0 && a <= 12'h3A3) begin
            for (int k = 0; k < 4; k++) begin
                int idx = 4 * int'(a - 12'h3A0) + k;
                if (idx < NI) r[8*k +: 8] = m_cfg[idx];
            end
        end else if (a >= 12'h3B0 && a <= 12'h3BF) begin
            int idx = int'(a - 12'h3B0);
            if (idx < NI) r = {2'b00, m_addr[idx]};
        end
        return r;
    endfunction

    task automatic model_write(input logic [11:0] a, input logic [31:0] d);
        for (int i = 0; i < NI; i++) begin
            if (m_cfg[i][7]) continue;
            if (a == 12'h3B0 + 12'(i)) m_addr[i] = d[29:0];
            else if (a == 12'h3A0 + 12'(i / 4)) m_cfg[i] = d[8*(i%4) +: 8] & 8'h9F;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_exports(input string req);
        for (int i = 0; i < NI; i++) begin
            check(req, {24'h0, entry_cfg[8*i +: 8]}, {24'h0, m_cfg[i]});
            check(req, entry_addr[32*i +: 32], {2'b00, m_addr[i]});
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        csr_wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NI; i++) begin
            m_cfg[i] = '0;
            m_addr[i] = '0;
        end
    endtask

    task automatic do_read(input logic [11:0] a, input string req);
        @(negedge clk);
        csr_wr_en = 1'b0;
        csr_addr = a;
        #1;
        check(req, csr_rdata, exp_rd(a));
        check(req, {31'h0, csr_hit}, {31'h0, exp_hit(a)});
    endtask

    // R9: old value before the edge, new value after it.
    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        csr_wdata = d;
        csr_wr_en = 1'b1;
        #1;
        check("R9 pre-edge", csr_rdata, exp_rd(a));
        @(posedge clk);
        #1;
        model_write(a, d);
        check("R9 post-edge", csr_rdata, exp_rd(a));
        @(negedge clk);
        csr_wr_en = 1'b0;
    endtask

    initial begin
        #(HALF * 2 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        for (int i = 0; i < NI; i++) begin
            m_cfg[i] = '0;
            m_addr[i] = '0;
        end
        // Drive nonzero values before reset so the clear is visible.
        repeat (2) @(negedge clk);
        csr_wdata = 32'hFFFF_FFFF;
        do_reset();

        // R1: everything reads zero after reset.
        for (int c = 0; c < 4; c++) do_read(12'h3A0 + 12'(c), "R1");
        for (int c = 0; c < 16; c++) do_read(12'h3B0 + 12'(c), "R1 R10");
        check_exports("R1");

        // R2: upper two address bits dropped.
        do_write(12'h3B1, 32'hFFFF_FFFF);
        do_read(12'h3B1, "R2");
        check("R2", entry_addr[63:32], 32'h3FFF_FFFF);

        // R3: byte layout of config CSR 0 and export bus.
        do_write(12'h3A0, 32'h0403_0201);
        for (int i = 0; i < NI; i++) check("R3", {24'h0, entry_cfg[8*i +: 8]}, 32'(i + 1));
        do_read(12'h3A0, "R3");

        // R4: reserved bits 6 and 5 cleared.
        do_write(12'h3A0, 32'h7F7F_7F7F);
        do_read(12'h3A0, "R4");
        check("R4", csr_rdata, 32'h1F1F_1F1F);

        // R5/R6: lock entry 2, then try to overwrite it.
        do_write(12'h3B2, 32'h0000_1234);
        do_write(12'h3A0, 32'h0088_0000);
        do_write(12'h3B2, 32'h0000_5678);
        do_read(12'h3B2, "R6");
        check("R6", csr_rdata, 32'h0000_1234);
        do_write(12'h3A0, 32'h1F1F_1F1F);
        do_read(12'h3A0, "R5");
        check("R5", csr_rdata, 32'h1F88_1F1F);
        check_exports("R5 R6");
        do_reset();
        do_read(12'h3A0, "R6 reset clears lock");
        do_write(12'h3B2, 32'h0000_0ABC);
        do_read(12'h3B2, "R6");
        check("R6", csr_rdata, 32'h0000_0ABC);

        // R7: unimplemented entries.
        do_write(12'h3B5, 32'h1234_5678);
        do_read(12'h3B5, "R7 R10");
        do_write(12'h3A1, 32'hFFFF_FFFF);
        do_read(12'h3A1, "R7 R10");
        check("R7", csr_rdata, 32'h0);
        check_exports("R7");

        // R8: foreign CSR numbers.
        do_write(12'h300, 32'hFFFF_FFFF);
        do_read(12'h300, "R8");
        check("R8", {31'h0, csr_hit}, 32'h0);
        do_write(12'h3A4, 32'h1F1F_1F1F);
        do_read(12'h3A4, "R8");
        do_read(12'h3B2, "R8 state kept");
        check_exports("R8");

        // Random mix, fewer locks, periodic reset.
        for (int n = 0; n < 600; n++) begin
            logic [11:0] a;
            logic [31:0] d;
            int unsigned k = $urandom % 8;
            if (n % 150 == 149) do_reset();
            if (k < 3) a = 12'h3A0 + 12'($urandom % 4);
            else if (k < 6) a = 12'h3B0 + 12'($urandom % 16);
            else a = 12'($urandom);
            d = $urandom;
            if ($urandom % 6 != 0) d = d & 32'h7F7F_7F7F;
            if ($urandom % 4 != 0) do_write(a, d);
            do_read(a, "R5 R6 R7 R8 random");
            do_read(($urandom % 2) ? 12'h3A0 + 12'($urandom % 4) : 12'h3B0 + 12'($urandom % 16),
                    "R2 R3 R4 random");
            check_exports("R3 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule